// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Register Sequencer

This block keeps the two programmable thresholds used by a deep FIFO's flag logic: the almost-empty level n and the almost-full level m. Each threshold is stored in two parts. The low part is one byte. The high part holds only the extra bits that the configured pointer width needs. Software cannot address the four parts directly. A single two-bit selection pointer picks the part that the next access uses, and the pointer steps in a fixed cycle: n low, n high, m low, m high, and then back to n low.

A configuration access happens while the load control `ld_n` is low. A write is taken when `wen1_n` is also low, and it stores the write bus into the selected part. A read is taken when both `ren1_n` and `ren2_n` are low, and it copies the selected part into the read-data register. Both kinds of access advance the same pointer. Raising `ld_n` ends a configuration session but leaves the pointer where it is, so a later session resumes at the next part.

While `ld_n` is high the block only decodes ordinary FIFO write and read requests for the surrounding design. The assembled thresholds are driven out continuously. Both write and read strobes are sampled on one clock here.

Top module: `flag_ofs_seq`

## Requirements
- R1: While reset is active, and after it is released, the pointer selects n low (index 0). Both thresholds equal 7: the low bytes are 07h and the high parts are 0. The read data is 0.
- R2: Successive configuration writes store into parts in the order n low (index 0), n high (1), m low (2), m high (3).
- R3: The write or read that follows an access at index 3 uses index 0 again.
- R4: Cycles with `ld_n` high do not move the pointer. The first access of the next session uses the part after the last one accessed.
- R5: A cycle with `ld_n`, `ren1_n` and `ren2_n` low and `wen1_n` high places the selected part on `rd_data` after the clock edge and advances the pointer. The low part goes on bits 7:0 and the high part on the low bits. The thresholds do not change.
- R6: With `ld_n` low, `wen1_n` high and at least one read enable high, no register, threshold, read data or pointer changes.
- R7: With `ld_n` high, `fifo_wr_sel` equals the inverse of `wen1_n` and `fifo_rd_sel` is high exactly when both read enables are low. No configuration state changes. Both strobes stay low while `ld_n` is low.
- R8: A low part stores bus bits 7:0 and a high part stores bits PTR_W-9:0. All other bus bits are discarded. Read data bits above the stored width are always 0.
- R9: When a configuration write and a configuration read fall in the same cycle, the write is performed and `rd_data` holds. The pointer advances by exactly one.
- R10: `ae_thr` is {n high, n low} and `af_thr` is {m high, m low}. Both reflect a write from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by write and read strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Load control, low selects configuration access |
| wen1_n | input | 1 | Write enable, active low |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| wr_data | input | DATA_W | Write-port data bus |
| rd_data | output | DATA_W | Registered read-port data |
| ae_thr | output | PTR_W | Assembled almost-empty threshold n |
| af_thr | output | PTR_W | Assembled almost-full threshold m |
| fifo_wr_sel | output | 1 | Ordinary FIFO write request decoded |
| fifo_rd_sel | output | 1 | Ordinary FIFO read request decoded |

## Verification
A pointer that is off by one does not show up as a wrong value on the cycle of the fault. It shows up as a write landing in a different threshold field, which is visible on `ae_thr` or `af_thr` right after that edge. It also shows up as a read returning a neighbouring part. For this reason the stimulus chains many short sessions without a reset between them, so that any drift in position is carried forward and caught at the next access. A bad mask appears at once in the upper bits of `rd_data` or of a threshold. A wrong collision priority appears as a change on `rd_data` in a cycle where a write was taken.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

    typedef enum logic [1:0] {
        SEL_AE_LO = 2'd0,
        SEL_AE_HI = 2'd1,
        SEL_AF_LO = 2'd2,
        SEL_AF_HI = 2'd3
    } ofs_sel_e;

    function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
        return ofs_sel_e'(cur + 2'd1);
    endfunction

    function automatic logic is_hi_part(input ofs_sel_e cur);
        return cur[0];
    endfunction

    function automatic logic thr_index(input ofs_sel_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/ofs_access_decode.sv
module ofs_access_decode (
    input  logic ld_n,
    input  logic wen1_n,
    input  logic ren1_n,
    input  logic ren2_n,
    output logic cfg_wr,
    output logic cfg_rd,
    output logic fifo_wr_sel,
    output logic fifo_rd_sel
);

    logic rd_req;
    logic wr_req;

    always_comb begin
        wr_req      = ~wen1_n;
        rd_req      = ~ren1_n & ~ren2_n;
        cfg_wr      = ~ld_n & wr_req;
        // write wins a collision; the read is dropped
        cfg_rd      = ~ld_n & rd_req & ~wr_req;
        fifo_wr_sel = ld_n & wr_req;
        fifo_rd_sel = ld_n & rd_req;
    end

endmodule

// File: rtl/ofs_sel_ptr.sv
module ofs_sel_ptr
    import flag_ofs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    output ofs_sel_e sel
);

    typedef struct packed {
        ofs_sel_e sel;
    } ptr_st_t;

    ptr_st_t st_d;
    ptr_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.sel = next_sel(st_q.sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel <= SEL_AE_LO;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel = st_q.sel;

endmodule

// File: rtl/ofs_regfile.sv
module ofs_regfile
    import flag_ofs_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int PTR_W  = 14,
    parameter int BYTE_W = 8,
    parameter int LO_RST = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  ofs_sel_e          sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  ae_thr,
    output logic [PTR_W-1:0]  af_thr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int HI_W   = PTR_W - BYTE_W;
    localparam int N_THR  = 2;

    typedef struct packed {
        logic [N_THR-1:0][BYTE_W-1:0] lo;
        logic [N_THR-1:0][HI_W-1:0]   hi;
        logic [DATA_W-1:0]            rd;
    } rf_st_t;

    rf_st_t st_d;
    rf_st_t st_q;

    logic [BYTE_W-1:0] wr_lo;
    logic [HI_W-1:0]   wr_hi;
    logic [DATA_W-1:0] sel_val;
    logic              idx;

    always_comb begin
        wr_lo = wr_data[BYTE_W-1:0];
        wr_hi = wr_data[HI_W-1:0];
        idx   = thr_index(sel);
        if (is_hi_part(sel)) begin
            sel_val = DATA_W'(st_q.hi[idx]);
        end else begin
            sel_val = DATA_W'(st_q.lo[idx]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            if (is_hi_part(sel)) begin
                st_d.hi[idx] = wr_hi;
            end else begin
                st_d.lo[idx] = wr_lo;
            end
        end else if (cfg_rd) begin
            st_d.rd = sel_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_THR; i++) begin
                st_q.lo[i] <= BYTE_W'(LO_RST);
                st_q.hi[i] <= '0;
            end
            st_q.rd <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [N_THR-1:0][PTR_W-1:0] thr;

    for (genvar g = 0; g < N_THR; g++) begin : g_thr
        assign thr[g] = {st_q.hi[g], st_q.lo[g]};
    end

    assign ae_thr  = thr[0];
    assign af_thr  = thr[1];
    assign rd_data = st_q.rd;

endmodule

// File: rtl/flag_ofs_seq.sv
module flag_ofs_seq
    import flag_ofs_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int PTR_W  = 14,
    parameter int BYTE_W = 8,
    parameter int LO_RST = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              wen1_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ae_thr,
    output logic [PTR_W-1:0]  af_thr,
    output logic              fifo_wr_sel,
    output logic              fifo_rd_sel
);

    logic     cfg_wr;
    logic     cfg_rd;
    logic     step;
    ofs_sel_e cur_sel;

    ofs_access_decode i_dec (
        .ld_n        (ld_n),
        .wen1_n      (wen1_n),
        .ren1_n      (ren1_n),
        .ren2_n      (ren2_n),
        .cfg_wr      (cfg_wr),
        .cfg_rd      (cfg_rd),
        .fifo_wr_sel (fifo_wr_sel),
        .fifo_rd_sel (fifo_rd_sel)
    );

    assign step = cfg_wr | cfg_rd;

    ofs_sel_ptr i_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .sel   (cur_sel)
    );

    ofs_regfile #(
        .DATA_W (DATA_W),
        .PTR_W  (PTR_W),
        .BYTE_W (BYTE_W),
        .LO_RST (LO_RST)
    ) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_rd  (cfg_rd),
        .sel     (cur_sel),
        .wr_data (wr_data),
        .ae_thr  (ae_thr),
        .af_thr  (af_thr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/flag_ofs_seq_chk.sv
module flag_ofs_seq_chk #(
    parameter int DATA_W = 9,
    parameter int PTR_W  = 14,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_n,
    input logic              wen1_n,
    input logic              ren1_n,
    input logic              ren2_n,
    input logic [DATA_W-1:0] rd_data,
    input logic [PTR_W-1:0]  ae_thr,
    input logic [PTR_W-1:0]  af_thr,
    input logic [1:0]        cur_sel
);

    logic acc;
    assign acc = !ld_n && (!wen1_n || (!ren1_n && !ren2_n));

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> cur_sel == 2'($past(cur_sel) + 2'd1)); // R3

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(cur_sel)); // R4

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n || wen1_n) |=> ($stable(ae_thr) && $stable(af_thr))); // R6

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n || !wen1_n || ren1_n || ren2_n) |=> $stable(rd_data)); // R9

    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:BYTE_W] == '0); // R8

endmodule

bind flag_ofs_seq flag_ofs_seq_chk #(
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W),
    .BYTE_W (BYTE_W)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_n    (ld_n),
    .wen1_n  (wen1_n),
    .ren1_n  (ren1_n),
    .ren2_n  (ren2_n),
    .rd_data (rd_data),
    .ae_thr  (ae_thr),
    .af_thr  (af_thr),
    .cur_sel (cur_sel)
);

// File: tb/test_flag_ofs_seq.sv
module test_flag_ofs_seq;

    localparam int DW = 9;
    localparam int PW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_n = 1'b1;
    logic          wen1_n = 1'b1;
    logic          ren1_n = 1'b1;
    logic          ren2_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [PW-1:0] ae_thr;
    logic [PW-1:0] af_thr;
    logic          fifo_wr_sel;
    logic          fifo_rd_sel;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0]    m_lo [2];
    logic [5:0]    m_hi [2];
    int            m_ptr;
    logic [DW-1:0] m_rd;

    always #2 clk = ~clk;

    flag_ofs_seq i_flag_ofs_seq (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wen1_n(wen1_n),
        .ren1_n(ren1_n), .ren2_n(ren2_n), .wr_data(wr_data),
        .rd_data(rd_data), .ae_thr(ae_thr), .af_thr(af_thr),
        .fifo_wr_sel(fifo_wr_sel), .fifo_rd_sel(fifo_rd_sel)
    );

    function automatic logic [PW-1:0] exp_thr(input int k);
        return {m_hi[k], m_lo[k]};
    endfunction

    function automatic logic [DW-1:0] part_val(input int p);
        if (p % 2 == 1) return DW'(m_hi[p/2]);
        return DW'(m_lo[p/2]);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_lo[k] = 8'h07;
            m_hi[k] = '0;
        end
        m_ptr = 0;
        m_rd  = '0;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; ld_n = 1'b1; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        model_reset();
        @(negedge clk);
        check(tag, "ae_thr in reset", ae_thr, exp_thr(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tag, "ae_thr", ae_thr, 14'd7);
        check(tag, "af_thr", af_thr, 14'd7);
        check(tag, "rd_data", rd_data, 0);
    endtask

    task automatic cyc(input bit ld, input bit w, input bit r1, input bit r2,
                       input logic [DW-1:0] d, input string tag);
        bit wr;
        bit rd;
        @(negedge clk);
        ld_n = ld; wen1_n = w; ren1_n = r1; ren2_n = r2; wr_data = d;
        #1;
        check("R7", "fifo_wr_sel", fifo_wr_sel, ld && !w);
        check("R7", "fifo_rd_sel", fifo_rd_sel, ld && !r1 && !r2);
        @(posedge clk);
        #1;
        wr = !ld && !w;
        rd = !ld && !r1 && !r2 && !wr;
        if (wr) begin
            if (m_ptr % 2 == 1) m_hi[m_ptr/2] = d[5:0];
            else                m_lo[m_ptr/2] = d[7:0];
            m_ptr = (m_ptr + 1) % 4;
        end else if (rd) begin
            m_rd  = part_val(m_ptr);
            m_ptr = (m_ptr + 1) % 4;
        end
        check(tag, "ae_thr", ae_thr, exp_thr(0));
        check(tag, "af_thr", af_thr, exp_thr(1));
        check(tag, "rd_data", rd_data, m_rd);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        model_reset();
        do_reset("R1");

        // R2: ordered fill of all four parts
        cyc(0, 0, 1, 1, 9'h0a1, "R2");
        cyc(0, 0, 1, 1, 9'h015, "R2");
        cyc(0, 0, 1, 1, 9'h0c3, "R2");
        cyc(0, 0, 1, 1, 9'h02a, "R2");
        // R3: fifth write wraps to n low
        cyc(0, 0, 1, 1, 9'h05e, "R3");
        // R4: partial session, pause, resume
        cyc(1, 1, 1, 1, 9'h000, "R4");
        cyc(1, 1, 0, 0, 9'h000, "R4");
        cyc(0, 0, 1, 1, 9'h033, "R4");
        cyc(1, 1, 1, 1, 9'h000, "R4");
        cyc(0, 0, 1, 1, 9'h077, "R4");
        // R5: read walk over all parts plus wrap
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 9'h000, "R5");
        // R6: no access
        cyc(0, 1, 1, 1, 9'h1ff, "R6");
        cyc(0, 1, 0, 1, 9'h1ff, "R6");
        cyc(0, 1, 1, 0, 9'h1ff, "R6");
        cyc(0, 0, 1, 1, 9'h011, "R6");
        // R7: ordinary FIFO traffic
        cyc(1, 0, 1, 1, 9'h1ff, "R7");
        cyc(1, 0, 0, 0, 9'h1ff, "R7");
        // R8: all-ones writes are masked
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 9'h1ff, "R8");
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 9'h000, "R8");
        // R9: collisions
        cyc(0, 0, 0, 0, 9'h0e4, "R9");
        cyc(0, 0, 0, 0, 9'h009, "R9");
        cyc(0, 1, 0, 0, 9'h000, "R9");
        // R10: random mix
        for (int i = 0; i < 600; i++) begin
            cyc(($urandom % 4) == 0, $urandom % 2, $urandom % 2, ($urandom % 4) == 0,
                DW'($urandom), "R10");
        end
        // R1: reset mid-run, pointer back to n low
        do_reset("R1");
        cyc(0, 0, 1, 1, 9'h0b2, "R1");
        check("R1", "ae_thr after first write", ae_thr, 14'h00b2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule